// File: doc/BRIEF.md
# Packet-Switched Tree Switch Node

This block is one switching node of a fat-tree packet network. Every 32-bit word carries its own destination leaf address in its low bits, so no route memory and no per-cycle schedule is needed. The node has three bidirectional links, one to its parent and one to each of its two children. Each link carries a word with a valid/ready handshake in both directions. A word arriving on any link is steered by address: it climbs toward the parent if it does not belong to this node's subtree. Otherwise one address bit, picked by the node's stage, sends it to the left or the right child.

The node is built from three steering units, one behind each input link, and three combining units, one in front of each output link. Each unit holds words in a 16-entry FIFO. When several inputs want the same output in the same cycle, a round-robin arbiter lets one of them through, and the others wait in their FIFOs. A full FIFO lowers ready toward whatever feeds it, so a stalled output backs traffic up into the network and no word is lost. Cycles with no valid word consume no routing slot.

Top module: `tsw_node`

## Requirements
- R1: The destination is data[ADDR_W-1:0]. If dest >> (LEVEL+1) differs from PREFIX, the word leaves on the parent output. Otherwise a 0 in bit LEVEL sends it to the left child output and a 1 sends it to the right child output. With the defaults (ADDR_W=4, LEVEL=1, PREFIX=2), destinations 8 and 9 go left, 10 and 11 go right, and all other destinations go to the parent.
- R2: Every word accepted on an input (valid and ready both high at a clock edge) leaves on exactly one output exactly once.
- R3: Words from one input to one output leave in the order in which they were accepted.
- R4: An input's ready is low while its FIFO holds DEPTH words. If an output is held not-ready and one input streams words to it, that input accepts exactly 2*DEPTH words and then keeps ready low.
- R5: While an output has valid high and ready low, it keeps valid high and its data unchanged in the next cycle.
- R6: Inputs are numbered parent=0, left=1, right=2. Each output grants one requesting input per cycle, taken in round-robin order from a pointer that moves to the input after the one granted. The pointer is 0 after reset. When all three inputs keep requesting one output, it serves them in the order 0, 1, 2, 0, 1, 2, and so on.
- R7: In the cycle after reset is released, every output valid is low and every input ready is high. With no traffic offered and all outputs ready, every output valid returns low once the node has drained.
- R8: A word accepted at clock edge E into an empty node whose outputs are ready shows up on its output with valid high after edge E+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_in_valid | input | 1 | Word offered by the parent |
| up_in_ready | output | 1 | Node can take a word from the parent |
| up_in_data | input | DATA_W | Word from the parent |
| up_out_valid | output | 1 | Word offered to the parent |
| up_out_ready | input | 1 | Parent can take a word |
| up_out_data | output | DATA_W | Word to the parent |
| lt_in_valid | input | 1 | Word offered by the left child |
| lt_in_ready | output | 1 | Node can take a word from the left child |
| lt_in_data | input | DATA_W | Word from the left child |
| lt_out_valid | output | 1 | Word offered to the left child |
| lt_out_ready | input | 1 | Left child can take a word |
| lt_out_data | output | DATA_W | Word to the left child |
| rt_in_valid | input | 1 | Word offered by the right child |
| rt_in_ready | output | 1 | Node can take a word from the right child |
| rt_in_data | input | DATA_W | Word from the right child |
| rt_out_valid | output | 1 | Word offered to the right child |
| rt_out_ready | input | 1 | Right child can take a word |
| rt_out_data | output | DATA_W | Word to the right child |

## Verification
The assertions check four things on every cycle. A stalled FIFO output holds its word, and a full FIFO stays full while its output is blocked. A head word is granted by at most one output. No arbiter serves the same input twice in a row while another input is waiting. Only the bench's scenarios can show the routing decision for each address, delivery exactly once in per-pair order under random stalls, the exact 2*DEPTH backpressure depth, the 0-1-2 rotation after reset and the two-edge latency, because each of these needs a word followed from input to output.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
package tsw_pkg;

    localparam int NPORT = 3;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_LEFT  = 2'd1,
        DIR_RIGHT = 2'd2
    } dir_e;

    typedef struct packed {
        logic vld;
        dir_e dir;
    } steer_t;

    // Upward on prefix mismatch, else the stage bit picks the child.
    function automatic dir_e route_dir(input int unsigned dest,
                                       input int unsigned level,
                                       input int unsigned prefix);
        if ((dest >> (level + 1)) != prefix)
            return DIR_UP;
        else if (((dest >> level) & 32'd1) != 32'd0)
            return DIR_RIGHT;
        else
            return DIR_LEFT;
    endfunction

endpackage

// File: rtl/tsw_fifo.sv
`timescale 1ns/1ps
module tsw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign in_ready  = (cnt != CW'(DEPTH));
    assign out_valid = (cnt != '0);
    assign out_data  = mem[rptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= in_data;
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // R5: a blocked head word stays put.
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: a full buffer that cannot drain keeps every word.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !out_ready) |=> (!in_ready && $stable(out_data)));

    // R7: empty right after reset.
    assert_reset_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: rtl/tsw_rr_arb.sv
`timescale 1ns/1ps
module tsw_rr_arb #(
    parameter int N = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [N-1:0]                        req,
    input  logic                                en,
    output logic [N-1:0]                        gnt,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] sel,
    output logic                                any
);
    localparam int SW = (N > 1) ? $clog2(N) : 1;

    logic [SW-1:0] ptr;

    always_comb begin
        gnt = '0;
        sel = ptr;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N)
                idx = idx - N;
            if (!any && en && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                sel      = SW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (any)
            ptr <= (sel == SW'(N - 1)) ? '0 : sel + 1'b1;
    end

    // R6: with others waiting, the last winner does not win again.
    assert_rr_fair_R6: assert property (@(posedge clk) disable iff (rst)
        (any && $past(any) && ($countones(req) > 1)) |-> (sel != $past(sel)));

endmodule

// File: rtl/tsw_split.sv
`timescale 1ns/1ps
module tsw_split
    import tsw_pkg::*;
#(
    parameter int          W      = 32,
    parameter int          DEPTH  = 16,
    parameter int          ADDR_W = 4,
    parameter int unsigned LEVEL  = 1,
    parameter int unsigned PREFIX = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [W-1:0]     in_data,
    output logic [NPORT-1:0] req,
    output logic [W-1:0]     head,
    input  logic [NPORT-1:0] gnt
);
    logic   head_valid;
    logic   take;
    steer_t st;

    tsw_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (head_valid),
        .out_ready (take),
        .out_data  (head)
    );

    always_comb begin
        st.vld = head_valid;
        st.dir = route_dir(32'(head[ADDR_W-1:0]), LEVEL, PREFIX);
    end

    assign req  = st.vld ? (NPORT'(1) << st.dir) : '0;
    assign take = |(gnt & req);

    // R2: a head word is claimed by at most one output.
    assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R6: no output grants an input that is not asking it.
    assert_grant_req_R6: assert property (@(posedge clk) disable iff (rst)
        ((gnt & ~req) == '0));

endmodule

// File: rtl/tsw_merge.sv
`timescale 1ns/1ps
module tsw_merge
    import tsw_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPORT-1:0]          req,
    input  logic [NPORT-1:0][W-1:0]   cand,
    output logic [NPORT-1:0]          gnt,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [W-1:0]              out_data
);
    localparam int SW = $clog2(NPORT);

    logic [SW-1:0] sel;
    logic          any;
    logic          room;

    tsw_rr_arb #(.N(NPORT)) arb_i (
        .clk (clk),
        .rst (rst),
        .req (req),
        .en  (room),
        .gnt (gnt),
        .sel (sel),
        .any (any)
    );

    tsw_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (any),
        .in_ready  (room),
        .in_data   (cand[sel]),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: rtl/tsw_node.sv
`timescale 1ns/1ps
module tsw_node
    import tsw_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          DEPTH  = 16,
    parameter int          ADDR_W = 4,
    parameter int unsigned LEVEL  = 1,
    parameter int unsigned PREFIX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_in_valid,
    output logic              up_in_ready,
    input  logic [DATA_W-1:0] up_in_data,
    output logic              up_out_valid,
    input  logic              up_out_ready,
    output logic [DATA_W-1:0] up_out_data,
    input  logic              lt_in_valid,
    output logic              lt_in_ready,
    input  logic [DATA_W-1:0] lt_in_data,
    output logic              lt_out_valid,
    input  logic              lt_out_ready,
    output logic [DATA_W-1:0] lt_out_data,
    input  logic              rt_in_valid,
    output logic              rt_in_ready,
    input  logic [DATA_W-1:0] rt_in_data,
    output logic              rt_out_valid,
    input  logic              rt_out_ready,
    output logic [DATA_W-1:0] rt_out_data
);
    logic [NPORT-1:0]              iv, ir, ov, orr;
    logic [NPORT-1:0][DATA_W-1:0]  id, od;
    logic [NPORT-1:0][DATA_W-1:0]  heads;
    logic [NPORT-1:0][NPORT-1:0]   sreq, sgnt;   // [source][output]
    logic [NPORT-1:0][NPORT-1:0]   mreq, mgnt;   // [output][source]

    assign iv  = {rt_in_valid, lt_in_valid, up_in_valid};
    assign id  = {rt_in_data, lt_in_data, up_in_data};
    assign orr = {rt_out_ready, lt_out_ready, up_out_ready};

    assign up_in_ready  = ir[0];
    assign lt_in_ready  = ir[1];
    assign rt_in_ready  = ir[2];
    assign up_out_valid = ov[0];
    assign lt_out_valid = ov[1];
    assign rt_out_valid = ov[2];
    assign up_out_data  = od[0];
    assign lt_out_data  = od[1];
    assign rt_out_data  = od[2];

    for (genvar s = 0; s < NPORT; s++) begin : g_xbar_s
        for (genvar o = 0; o < NPORT; o++) begin : g_xbar_o
            assign mreq[o][s] = sreq[s][o];
            assign sgnt[s][o] = mgnt[o][s];
        end
    end

    for (genvar s = 0; s < NPORT; s++) begin : g_split
        tsw_split #(
            .W      (DATA_W),
            .DEPTH  (DEPTH),
            .ADDR_W (ADDR_W),
            .LEVEL  (LEVEL),
            .PREFIX (PREFIX)
        ) split_i (
            .clk      (clk),
            .rst      (rst),
            .in_valid (iv[s]),
            .in_ready (ir[s]),
            .in_data  (id[s]),
            .req      (sreq[s]),
            .head     (heads[s]),
            .gnt      (sgnt[s])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_merge
        tsw_merge #(
            .W     (DATA_W),
            .DEPTH (DEPTH)
        ) merge_i (
            .clk       (clk),
            .rst       (rst),
            .req       (mreq[o]),
            .cand      (heads),
            .gnt       (mgnt[o]),
            .out_valid (ov[o]),
            .out_ready (orr[o]),
            .out_data  (od[o])
        );
    end

endmodule

// File: tb/tsw_node_tb_top.sv
`timescale 1ns/1ps
module tsw_node_tb_top;

    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int LVL   = 1;
    localparam int PFX   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          in_vld [3];
    logic          in_rdy [3];
    logic [DW-1:0] in_data[3];
    logic          out_vld[3];
    logic          out_rdy[3];
    logic [DW-1:0] out_data[3];

    int checks = 0;
    int errors = 0;
    int sent_cnt [3][3];
    int rcv_cnt  [3][3];
    int mon_pct = 100;
    bit mon_hold [3];
    bit log_en = 0;
    int log_n = 0;
    int log_src [64];

    tsw_node #(.DATA_W(DW), .DEPTH(DEPTH), .ADDR_W(AW), .LEVEL(LVL), .PREFIX(PFX)) dut_i (
        .clk(clk), .rst(rst),
        .up_in_valid(in_vld[0]), .up_in_ready(in_rdy[0]), .up_in_data(in_data[0]),
        .up_out_valid(out_vld[0]), .up_out_ready(out_rdy[0]), .up_out_data(out_data[0]),
        .lt_in_valid(in_vld[1]), .lt_in_ready(in_rdy[1]), .lt_in_data(in_data[1]),
        .lt_out_valid(out_vld[1]), .lt_out_ready(out_rdy[1]), .lt_out_data(out_data[1]),
        .rt_in_valid(in_vld[2]), .rt_in_ready(in_rdy[2]), .rt_in_data(in_data[2]),
        .rt_out_valid(out_vld[2]), .rt_out_ready(out_rdy[2]), .rt_out_data(out_data[2])
    );

    // R1 expectation: 0 parent, 1 left, 2 right
    function automatic int exp_port(int d);
        if ((d >> (LVL + 1)) != PFX) return 0;
        return (((d >> LVL) & 1) != 0) ? 2 : 1;
    endfunction

    // word: [31:30] source, [29:14] sequence, [3:0] destination
    function automatic logic [DW-1:0] make_word(int src, int d);
        logic [15:0] sq;
        sq = 16'(sent_cnt[src][exp_port(d)]);
        return {2'(src), sq, 10'd0, 4'(d)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic monitor(int p);
        forever begin
            @(negedge clk);
            out_rdy[p] = !mon_hold[p] && (($urandom % 100) < mon_pct);
            #1;
            if (!rst && out_vld[p] && out_rdy[p]) begin
                int src, sq, d;
                src = int'(out_data[p][31:30]);
                sq  = int'(out_data[p][29:14]);
                d   = int'(out_data[p][3:0]);
                check(exp_port(d) == p, "R1 output port", p, exp_port(d));
                if (src < 3) begin
                    check(sq == (rcv_cnt[src][p] & 16'hFFFF), "R3 order", sq, rcv_cnt[src][p]);
                    rcv_cnt[src][p]++;
                end else
                    check(0, "R2 bad source", src, 0);
                if (log_en && p == 1 && log_n < 64) begin
                    log_src[log_n] = src;
                    log_n++;
                end
            end
        end
    endtask

    task automatic inject(int src, int n, int fixed_dest, int idle_pct);
        for (int k = 0; k < n; k++) begin
            int d;
            d = (fixed_dest >= 0) ? fixed_dest : int'($urandom % 16);
            @(negedge clk);
            while (($urandom % 100) < idle_pct) begin
                in_vld[src] = 1'b0;
                @(negedge clk);
            end
            in_vld[src]  = 1'b1;
            in_data[src] = make_word(src, d);
            #1;
            while (!in_rdy[src]) begin
                @(negedge clk);
                #1;
            end
            sent_cnt[src][exp_port(d)]++;
        end
        @(negedge clk);
        in_vld[src] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            in_vld[i] = 1'b0;
            in_data[i] = '0;
            mon_hold[i] = 1'b0;
            for (int j = 0; j < 3; j++) begin
                sent_cnt[i][j] = 0;
                rcv_cnt[i][j] = 0;
            end
        end
        mon_pct = 100;
        log_en = 0;
        log_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_pairs(string tag);
        for (int s = 0; s < 3; s++)
            for (int p = 0; p < 3; p++)
                check(rcv_cnt[s][p] == sent_cnt[s][p], tag, rcv_cnt[s][p], sent_cnt[s][p]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            in_vld[i] = 1'b0;
            in_data[i] = '0;
            out_rdy[i] = 1'b0;
            mon_hold[i] = 1'b0;
        end
        for (int p = 0; p < 3; p++) begin
            automatic int pp = p;
            fork monitor(pp); join_none
        end

        // T1 reset state (R7)
        do_reset();
        #1;
        for (int i = 0; i < 3; i++) begin
            check(out_vld[i] == 1'b0, "R7 out valid after reset", int'(out_vld[i]), 0);
            check(in_rdy[i] == 1'b1, "R7 in ready after reset", int'(in_rdy[i]), 1);
        end

        // T2 two-edge latency (R8): parent -> dest 8 -> left
        do_reset();
        @(negedge clk);
        in_vld[0]  = 1'b1;
        in_data[0] = make_word(0, 8);
        #1;
        check(in_rdy[0] == 1'b1, "R8 accept", int'(in_rdy[0]), 1);
        sent_cnt[0][1]++;
        @(negedge clk);
        in_vld[0] = 1'b0;
        #1;
        check(out_vld[1] == 1'b0, "R8 not before E+1", int'(out_vld[1]), 0);
        @(negedge clk);
        #1;
        check(out_vld[1] == 1'b1, "R8 valid after E+1", int'(out_vld[1]), 1);
        check(out_data[1][3:0] == 4'd8, "R8 data", int'(out_data[1][3:0]), 8);
        repeat (5) @(negedge clk);
        check_pairs("R2 latency word");

        // T3 sweep of every destination from every input (R1, R2, R3)
        do_reset();
        fork
            begin for (int d = 0; d < 16; d++) inject(0, 1, d, 0); end
            begin for (int d = 0; d < 16; d++) inject(1, 1, d, 0); end
            begin for (int d = 0; d < 16; d++) inject(2, 1, d, 0); end
        join
        repeat (40) @(negedge clk);
        check_pairs("R2 sweep");

        // T4 backpressure depth and stall hold (R4, R5)
        do_reset();
        mon_hold[0] = 1'b1;
        begin
            int acc;
            logic [DW-1:0] held;
            acc = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                in_vld[1]  = 1'b1;
                in_data[1] = make_word(1, 0);
                #1;
                if (in_rdy[1]) begin
                    acc++;
                    sent_cnt[1][0]++;
                end
            end
            @(negedge clk);
            in_vld[1] = 1'b0;
            #1;
            check(acc == 2 * DEPTH, "R4 accepted words", acc, 2 * DEPTH);
            check(in_rdy[1] == 1'b0, "R4 ready low when full", int'(in_rdy[1]), 0);
            held = out_data[0];
            check(out_vld[0] == 1'b1, "R5 valid under stall", int'(out_vld[0]), 1);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                #1;
                check(out_vld[0] == 1'b1 && out_data[0] == held, "R5 stable under stall",
                      int'(out_data[0][29:14]), int'(held[29:14]));
            end
        end
        mon_hold[0] = 1'b0;
        repeat (60) @(negedge clk);
        check(rcv_cnt[1][0] == 2 * DEPTH, "R2 drained after stall", rcv_cnt[1][0], 2 * DEPTH);

        // T5 round-robin rotation after reset (R6)
        do_reset();
        mon_hold[1] = 1'b1;
        log_en = 1;
        fork
            inject(0, 8, 8, 0);
            inject(1, 8, 9, 0);
            inject(2, 8, 8, 0);
        join
        mon_hold[1] = 1'b0;
        repeat (40) @(negedge clk);
        check(log_n == 24, "R6 words seen", log_n, 24);
        for (int k = 0; k < 24; k++)
            check(log_src[k] == k % 3, "R6 rotation order", log_src[k], k % 3);
        log_en = 0;

        // T6 random traffic with random stalls (R1, R2, R3, R7)
        do_reset();
        mon_pct = 60;
        fork
            inject(0, 250, -1, 30);
            inject(1, 250, -1, 30);
            inject(2, 250, -1, 30);
        join
        mon_pct = 100;
        repeat (100) @(negedge clk);
        check_pairs("R2 random");
        #1;
        for (int i = 0; i < 3; i++)
            check(out_vld[i] == 1'b0, "R7 idle after drain", int'(out_vld[i]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule